// File: doc/BRIEF.md
# Burst Memory Bus-Cycle Controller

This block sits in front of a pipelined synchronous burst memory array. Each clock it decodes three control strobes into one of three actions: start a new access at the presented address, carry the running burst forward, or idle. It then issues the internal array access for that clock. A double-rate access is described as two beats within one clock. The design therefore runs on a single clock and reports the two beat addresses side by side.

The two least significant address bits advance through a burst of four. They follow either an interleaved order (start XOR index) or a linear order (start plus index, modulo four). The order is chosen when the burst is loaded. The upper address bits stay fixed for the whole burst.

Every output is registered at the edge that samples the command. The output-enable strobe follows the read enable by one more clock, which matches the point where read data leaves the output registers. The block also raises a flag for two protocol misuses:
- a write that directly follows a read with no idle cycle between them;
- a continue issued while no burst is running.

Top module: `burst_cycle_ctrl`

## Requirements
- R1: With `ld_n` low at a clock edge, a new burst starts at `addr`. `rd_wr`=1 selects read and `rd_wr`=0 selects write. `sdr`=1 selects one beat per clock and `sdr`=0 selects two. The matching enable, beat count and addresses appear on the outputs in the clock after that edge.
- R2: With `ld_n` high and `rd_wr` high during a running burst, the burst continues. It keeps the direction, rate and order captured at its load.
- R3: With `ld_n` high and `rd_wr` low, the cycle idles: both enables low, beat count 0, both beat addresses 0 and `seq_err` low in the next clock. Any running burst ends.
- R4: `beat_cnt` is 1 for a single-rate cycle, 2 for a double-rate cycle and 0 when idle. `beat1_addr` is 0 whenever `beat_cnt` is below 2.
- R5: When `lin_order` was 0 at load (interleaved), the low two bits of beat k are the start low bits XOR k.
- R6: When `lin_order` was 1 at load (linear), the low two bits of beat k are (start low bits + k) mod 4. The value of `lin_order` during continue cycles has no effect.
- R7: The beat index k starts at 0 on a load and advances by the beat count of every cycle of the burst. Beyond the fourth beat it wraps modulo 4, so further continues revisit the same four addresses.
- R8: Address bits above bit 1 on both beat outputs equal those of the load address for the whole burst. `addr` is ignored on continue cycles.
- R9: `oe` is high exactly in the clock after a clock in which `rd_en` was high. It therefore drops one clock after the first idle cycle that follows a read.
- R10: A write load in a clock where `rd_en` is high (a read immediately before it) sets `seq_err` for one clock. The write is still issued.
- R11: A continue with no running burst (after reset or after an idle cycle) behaves as an idle cycle and sets `seq_err` for one clock.
- R12: While `rst_n` is low, all outputs are 0 and no burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Low: load a new address; high: continue or idle |
| rd_wr | input | 1 | On load 1=read 0=write; with `ld_n` high 1=continue 0=idle |
| sdr | input | 1 | On load 1=single rate, 0=double rate |
| lin_order | input | 1 | On load 1=linear order, 0=interleaved |
| addr | input | ADDR_W | External address, sampled on load |
| beat0_addr | output | ADDR_W | Array address of the first beat of this clock |
| beat1_addr | output | ADDR_W | Array address of the second beat (0 unless double rate) |
| rd_en | output | 1 | Array read in this clock |
| wr_en | output | 1 | Array write in this clock |
| beat_cnt | output | 2 | Beats in this clock: 0, 1 or 2 |
| oe | output | 1 | Output drivers enabled for read data |
| seq_err | output | 1 | Illegal command sequence seen at the last edge |

## Verification
The hardest situations to reach are the wrapped beat index and the rate-dependent index step. Both need a burst driven well past its fourth beat with every start offset, both orders and both rates. The bench sweeps all 32 such combinations. Each burst gets a load and four continues, which is enough to wrap the index twice at double rate. During the continues the bench drives a different address and the opposite order select, so it would catch any leak of those inputs. Directed sequences then produce the two misuse cases and their legal counterparts: a read-write pair separated by an idle cycle, and a write followed by a read.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_LOAD = 2'd1,
      CMD_CONT = 2'd2
   } bcc_cmd_e;

   localparam int unsigned BCC_LANES = 2;
endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
   import bcc_pkg::*;
(
   input  logic     ld_n,
   input  logic     rd_wr,
   input  logic     burst_live,
   input  logic     prev_read,
   output bcc_cmd_e cmd,
   output logic     orphan_cont,
   output logic     rw_hazard
);
   always_comb begin
      cmd         = CMD_IDLE;
      orphan_cont = 1'b0;
      rw_hazard   = 1'b0;
      if (!ld_n) begin
         cmd       = CMD_LOAD;
         rw_hazard = !rd_wr && prev_read;
      end else if (rd_wr) begin
         if (burst_live) begin
            cmd = CMD_CONT;
         end else begin
            orphan_cont = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bcc_beat_addr.sv
module bcc_beat_addr #(
   parameter int LOW_W = 2
) (
   input  logic [LOW_W-1:0] start_low,
   input  logic [LOW_W-1:0] beat_idx,
   input  logic             linear,
   output logic [LOW_W-1:0] beat_low
);
   logic [LOW_W-1:0] lin_low;
   logic [LOW_W-1:0] ilv_low;

   assign lin_low  = start_low + beat_idx;
   assign ilv_low  = start_low ^ beat_idx;
   assign beat_low = linear ? lin_low : ilv_low;
endmodule

// File: rtl/burst_cycle_ctrl.sv
module burst_cycle_ctrl
   import bcc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              rd_wr,
   input  logic              sdr,
   input  logic              lin_order,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] beat0_addr,
   output logic [ADDR_W-1:0] beat1_addr,
   output logic              rd_en,
   output logic              wr_en,
   output logic [1:0]        beat_cnt,
   output logic              oe,
   output logic              seq_err
);
   localparam int LOW_W = $clog2(BURST_LEN);
   localparam int UP_W  = ADDR_W - LOW_W;

   generate
      if (BURST_LEN < 2 || (1 << LOW_W) != BURST_LEN) begin : g_bad_len
         $error("burst_cycle_ctrl: BURST_LEN must be a power of two >= 2");
      end
      if (UP_W < 1) begin : g_bad_aw
         $error("burst_cycle_ctrl: ADDR_W must exceed the burst index width");
      end
   endgenerate

   // burst context captured at load
   logic             live_q;
   logic             dir_rd_q;
   logic             single_q;
   logic             linear_q;
   logic [UP_W-1:0]  upper_q;
   logic [LOW_W-1:0] start_q;
   logic [LOW_W-1:0] idx_q;

   bcc_cmd_e cmd;
   logic     orphan_cont;
   logic     rw_hazard;

   bcc_decode u_dec (
      .ld_n        (ld_n),
      .rd_wr       (rd_wr),
      .burst_live  (live_q),
      .prev_read   (rd_en),
      .cmd         (cmd),
      .orphan_cont (orphan_cont),
      .rw_hazard   (rw_hazard)
   );

   // selected context for this clock
   logic             go;
   logic             cur_rd;
   logic             cur_single;
   logic             cur_linear;
   logic [UP_W-1:0]  cur_upper;
   logic [LOW_W-1:0] cur_start;
   logic [LOW_W-1:0] cur_idx;
   logic [LOW_W-1:0] step;

   always_comb begin
      go         = (cmd != CMD_IDLE);
      cur_rd     = dir_rd_q;
      cur_single = single_q;
      cur_linear = linear_q;
      cur_upper  = upper_q;
      cur_start  = start_q;
      cur_idx    = idx_q;
      if (cmd == CMD_LOAD) begin
         cur_rd     = rd_wr;
         cur_single = sdr;
         cur_linear = lin_order;
         cur_upper  = addr[ADDR_W-1:LOW_W];
         cur_start  = addr[LOW_W-1:0];
         cur_idx    = '0;
      end
      step = cur_single ? LOW_W'(1) : LOW_W'(2);
   end

   logic [ADDR_W-1:0] lane_addr [BCC_LANES];

   genvar gi;
   generate
      for (gi = 0; gi < BCC_LANES; gi++) begin : g_lane
         logic [LOW_W-1:0] lane_low;
         bcc_beat_addr #(.LOW_W(LOW_W)) u_ba (
            .start_low (cur_start),
            .beat_idx  (cur_idx + LOW_W'(gi)),
            .linear    (cur_linear),
            .beat_low  (lane_low)
         );
         assign lane_addr[gi] = {cur_upper, lane_low};
      end
   endgenerate

   // context registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q   <= 1'b0;
         dir_rd_q <= 1'b0;
         single_q <= 1'b1;
         linear_q <= 1'b0;
         upper_q  <= '0;
         start_q  <= '0;
         idx_q    <= '0;
      end else begin
         live_q   <= go;
         dir_rd_q <= cur_rd;
         single_q <= cur_single;
         linear_q <= cur_linear;
         upper_q  <= cur_upper;
         start_q  <= cur_start;
         idx_q    <= go ? (cur_idx + step) : '0;
      end
   end

   // output registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat0_addr <= '0;
         beat1_addr <= '0;
         rd_en      <= 1'b0;
         wr_en      <= 1'b0;
         beat_cnt   <= 2'd0;
         oe         <= 1'b0;
         seq_err    <= 1'b0;
      end else begin
         beat0_addr <= go ? lane_addr[0] : '0;
         beat1_addr <= (go && !cur_single) ? lane_addr[1] : '0;
         rd_en      <= go && cur_rd;
         wr_en      <= go && !cur_rd;
         beat_cnt   <= !go ? 2'd0 : (cur_single ? 2'd1 : 2'd2);
         oe         <= rd_en;
         seq_err    <= orphan_cont || rw_hazard;
      end
   end
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_n,
   input logic              rd_wr,
   input logic              sdr,
   input logic [ADDR_W-1:0] beat0_addr,
   input logic [ADDR_W-1:0] beat1_addr,
   input logic              rd_en,
   input logic              wr_en,
   input logic [1:0]        beat_cnt,
   input logic              oe,
   input logic              seq_err
);
   a_r1_single_read_issued: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && rd_wr && sdr) |=> (rd_en && !wr_en && beat_cnt == 2'd1));

   a_r3_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_n && !rd_wr) |=> (beat_cnt == 2'd0 && !rd_en && !wr_en && !seq_err
                            && beat0_addr == '0));

   a_r4_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_cnt != 2'd3) && ((beat_cnt != 2'd0) == (rd_en ^ wr_en)));

   a_r8_upper_shared: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_cnt == 2'd2) |-> (beat0_addr[ADDR_W-1:2] == beat1_addr[ADDR_W-1:2]));

   a_r9_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_n && !rd_wr) |=> ##1 !oe);

   a_r10_turnaround_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !rd_wr && rd_en) |=> (seq_err && wr_en));

   a_r11_orphan_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_n && rd_wr && !rd_en && !wr_en) |=> (seq_err && beat_cnt == 2'd0));
endmodule

bind burst_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_n       (ld_n),
   .rd_wr      (rd_wr),
   .sdr        (sdr),
   .beat0_addr (beat0_addr),
   .beat1_addr (beat1_addr),
   .rd_en      (rd_en),
   .wr_en      (wr_en),
   .beat_cnt   (beat_cnt),
   .oe         (oe),
   .seq_err    (seq_err)
);

// File: tb/burst_cycle_ctrl_tb_top.sv
module burst_cycle_ctrl_tb_top;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b1;
   logic          rd_wr = 1'b0;
   logic          sdr = 1'b1;
   logic          lin_order = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [AW-1:0] beat0_addr, beat1_addr;
   logic          rd_en, wr_en, oe, seq_err;
   logic [1:0]    beat_cnt;

   int n_chk = 0;
   int n_bad = 0;

   // model of the requirements
   logic          m_live = 1'b0;
   logic          m_rd = 1'b0;
   logic          m_single = 1'b1;
   logic          m_lin = 1'b0;
   logic [AW-3:0] m_up = '0;
   logic [1:0]    m_start = '0;
   logic [1:0]    m_idx = '0;
   logic          m_prev_rd = 1'b0;

   always #5 clk = ~clk;

   burst_cycle_ctrl #(.ADDR_W(AW), .BURST_LEN(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_wr(rd_wr), .sdr(sdr),
      .lin_order(lin_order), .addr(addr), .beat0_addr(beat0_addr),
      .beat1_addr(beat1_addr), .rd_en(rd_en), .wr_en(wr_en),
      .beat_cnt(beat_cnt), .oe(oe), .seq_err(seq_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] order_low(input logic lin, input logic [1:0] st,
                                            input logic [1:0] k);
      return lin ? 2'(st + k) : (st ^ k);
   endfunction

   task automatic step(input logic l_n, input logic rw, input logic s,
                       input logic lo, input logic [AW-1:0] a);
      logic          go;
      logic          e_ill;
      logic          e_oe;
      logic [1:0]    nb;
      logic [AW-1:0] e0, e1;
      @(negedge clk);
      ld_n = l_n; rd_wr = rw; sdr = s; lin_order = lo; addr = a;
      e_ill = (l_n && rw && !m_live) || (!l_n && !rw && m_prev_rd);
      if (!l_n) begin
         m_rd = rw; m_single = s; m_lin = lo;
         m_up = a[AW-1:2]; m_start = a[1:0]; m_idx = 2'd0;
         go = 1'b1;
      end else begin
         go = rw && m_live;
      end
      nb = !go ? 2'd0 : (m_single ? 2'd1 : 2'd2);
      e0 = go ? {m_up, order_low(m_lin, m_start, m_idx)} : '0;
      e1 = (nb == 2'd2) ? {m_up, order_low(m_lin, m_start, 2'(m_idx + 2'd1))} : '0;
      e_oe = m_prev_rd;
      @(posedge clk);
      #1;
      check("R1/R2 rd_en", int'(rd_en), int'(go && m_rd));
      check("R1/R2 wr_en", int'(wr_en), int'(go && !m_rd));
      check("R4 beat_cnt", int'(beat_cnt), int'(nb));
      check(m_lin ? "R6/R7/R8 beat0" : "R5/R7/R8 beat0", int'(beat0_addr), int'(e0));
      check("R4/R5/R6 beat1", int'(beat1_addr), int'(e1));
      check("R10/R11 seq_err", int'(seq_err), int'(e_ill));
      check("R9 oe", int'(oe), int'(e_oe));
      m_idx     = 2'(m_idx + nb);
      m_live    = go;
      m_prev_rd = go && m_rd;
   endtask

   initial begin : watchdog
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      #1;
      // R12: reset state
      check("R12 rd_en", int'(rd_en), 0);
      check("R12 wr_en", int'(wr_en), 0);
      check("R12 beat_cnt", int'(beat_cnt), 0);
      check("R12 oe", int'(oe), 0);
      check("R12 seq_err", int'(seq_err), 0);
      check("R12 beat0", int'(beat0_addr), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: continue right after reset
      step(1'b1, 1'b1, 1'b1, 1'b0, 8'h3C);

      // sweep: order x start x rate x direction, load plus four continues
      for (int lo = 0; lo < 2; lo++) begin
         for (int st = 0; st < 4; st++) begin
            for (int s = 0; s < 2; s++) begin
               for (int rw = 0; rw < 2; rw++) begin
                  logic [AW-1:0] base;
                  base = AW'((lo * 64) + (st * 16) + (s * 8) + (rw * 4) + 32 + st);
                  step(1'b0, rw[0], s[0], lo[0], base);
                  for (int c = 0; c < 4; c++)
                     step(1'b1, 1'b1, ~s[0], ~lo[0], ~base);   // R2/R6/R8 ignored inputs
                  step(1'b1, 1'b0, 1'b1, 1'b0, 8'hFF);        // R3 idle
               end
            end
         end
      end

      // R11: continue after idle
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
      // R10: write straight after read
      step(1'b0, 1'b1, 1'b0, 1'b1, 8'h45);
      step(1'b0, 1'b0, 1'b1, 1'b0, 8'h9A);
      // write followed by read is legal
      step(1'b0, 1'b1, 1'b1, 1'b0, 8'h72);
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
      // read, idle, write is legal
      step(1'b0, 1'b0, 1'b0, 1'b0, 8'hE1);
      step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
      step(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule